// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test front end of a chip that carries boundary-scan logic. It has four controls: a test clock, a mode-select line, a serial data input and a serial data output with an output enable. A sixteen-state controller follows the mode-select level on each rising test-clock edge. Around it sit an instruction register with separate capture/shift and shadow stages, a one-stage bypass register and a falling-edge output stage that drives the serial output.

The instruction register has a parity bit in its top position. The active instruction is decoded into two things: a flag that tells the chip core whether it runs its normal function or is under test, and a select code that picks the external data register the serial path goes through. An opcode with odd parity, or one that matches no supported instruction, acts as bypass. The external data registers (boundary cells, control register) are outside the block. They receive capture, shift and update strobes and the select code, and they return their serial output on a single input pin. A test-logic reset output tells them to reload their power-up values.

Top module: `scan_tap_ctrl`

## Requirements
- R1: After power-on reset, and whenever the controller is in Test-Logic-Reset, `logic_reset` is 1, the active instruction is all ones (bypass), `test_mode` is 0, `dr_sel` is 0 and `tdo_en` is 0.
- R2: The controller moves between the sixteen standard states on each rising `tck` edge according to `tms`. `logic_reset` is 1 in Test-Logic-Reset and 0 in every other state.
- R3: Five consecutive rising edges with `tms` at 1 bring the controller to Test-Logic-Reset from any state.
- R4: In Capture-IR the instruction shift stage loads 8'b1000_0001. During the eight Shift-IR cycles this pattern leaves on `tdo` least-significant bit first, while the new opcode enters from `tdi`.
- R5: `tdo_en` rises on the falling edge after Shift-DR or Shift-IR is entered and falls on the falling edge after Exit1-DR or Exit1-IR is entered. `tdo` changes only on falling edges and first shows bit 0. Shifting happens on each rising edge that is taken in a shift state.
- R6: A newly shifted opcode becomes active on the falling edge in Update-IR. Until then `test_mode` and `dr_sel` keep their previous values.
- R7: Bit 7 is an even-parity bit. An opcode with an odd number of ones is executed as bypass (`test_mode` 0, `dr_sel` 0).
- R8: For an opcode with even parity, bits 6:0 decode as follows: 0x00 gives test mode with the boundary path (`dr_sel` 1); 0x02 gives normal mode with the boundary path; 0x03 gives test mode with the control path (`dr_sel` 2). Any other value gives bypass (normal mode, `dr_sel` 0).
- R9: When bypass is selected, Capture-DR clears the bypass stage. `tdo` then shows `tdi` delayed by one shift, and `dr_capture`, `dr_shift` and `dr_update` stay 0.
- R10: When a non-bypass path is selected, `dr_capture` is 1 in Capture-DR and `dr_shift` is 1 in Shift-DR. `dr_update` is 1 from the falling edge in Update-DR until the next falling edge. During Shift-DR, `tdo` shows `dr_tdo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in |
| dr_tdo | input | 1 | Serial output of the selected external data register |
| tdo | output | 1 | Serial data out, valid while tdo_en is 1 |
| tdo_en | output | 1 | Output enable of tdo; 0 means high impedance |
| logic_reset | output | 1 | Controller is in Test-Logic-Reset |
| dr_capture | output | 1 | External data register capture strobe |
| dr_shift | output | 1 | External data register shift strobe |
| dr_update | output | 1 | External data register update strobe, falling-edge timed |
| dr_sel | output | 2 | Selected data path: 0 bypass, 1 boundary, 2 control |
| test_mode | output | 1 | Core function is under test when 1 |

## Verification
The state-decoded outputs (`logic_reset`, `dr_capture`, `dr_shift`) follow the rising edge that enters a state. The falling-edge outputs (`tdo`, `tdo_en`, `dr_update`) and the active instruction settle half a cycle later, on the falling edge of that same cycle. The bench drives `tms` and `tdi` just after a falling edge and advances one full cycle per step. It then samples 1 ns after the next falling edge, so every result of the state entered in that step has settled. The bench keeps its own model of the state graph to predict `logic_reset` and `tdo_en` over a long pseudo-random walk, and it sweeps all 256 opcodes through a full instruction scan.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

   typedef enum logic [3:0] {
      ST_RESET, ST_IDLE,
      ST_DR_SEL, ST_DR_CAP, ST_DR_SHF, ST_DR_EX1, ST_DR_PAU, ST_DR_EX2, ST_DR_UPD,
      ST_IR_SEL, ST_IR_CAP, ST_IR_SHF, ST_IR_EX1, ST_IR_PAU, ST_IR_EX2, ST_IR_UPD
   } tap_state_e;

   localparam int PATH_W = 2;
   localparam logic [PATH_W-1:0] PATH_BYPASS   = 2'd0;
   localparam logic [PATH_W-1:0] PATH_BOUNDARY = 2'd1;
   localparam logic [PATH_W-1:0] PATH_CONTROL  = 2'd2;

   typedef struct packed {
      logic              test;
      logic [PATH_W-1:0] path;
   } insn_t;

   function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
      tap_state_e n;
      case (s)
         ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
         ST_IDLE:   n = m ? ST_DR_SEL : ST_IDLE;
         ST_DR_SEL: n = m ? ST_IR_SEL : ST_DR_CAP;
         ST_DR_CAP: n = m ? ST_DR_EX1 : ST_DR_SHF;
         ST_DR_SHF: n = m ? ST_DR_EX1 : ST_DR_SHF;
         ST_DR_EX1: n = m ? ST_DR_UPD : ST_DR_PAU;
         ST_DR_PAU: n = m ? ST_DR_EX2 : ST_DR_PAU;
         ST_DR_EX2: n = m ? ST_DR_UPD : ST_DR_SHF;
         ST_DR_UPD: n = m ? ST_DR_SEL : ST_IDLE;
         ST_IR_SEL: n = m ? ST_RESET  : ST_IR_CAP;
         ST_IR_CAP: n = m ? ST_IR_EX1 : ST_IR_SHF;
         ST_IR_SHF: n = m ? ST_IR_EX1 : ST_IR_SHF;
         ST_IR_EX1: n = m ? ST_IR_UPD : ST_IR_PAU;
         ST_IR_PAU: n = m ? ST_IR_EX2 : ST_IR_PAU;
         ST_IR_EX2: n = m ? ST_IR_UPD : ST_IR_SHF;
         ST_IR_UPD: n = m ? ST_DR_SEL : ST_IDLE;
         default:   n = ST_RESET;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
   import scan_tap_pkg::*;
(
   input  logic       tck,
   input  logic       por_n,
   input  logic       tms,
   output tap_state_e st
);

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) st <= ST_RESET;
      else        st <= tap_next(st, tms);
   end

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
   import scan_tap_pkg::*;
#(
   parameter int               IR_W         = 8,
   parameter logic [IR_W-1:0]  CAP_PAT      = {1'b1, {(IR_W-2){1'b0}}, 1'b1},
   parameter bit               PARITY_CHECK = 1'b1
) (
   input  logic            tck,
   input  logic            por_n,
   input  tap_state_e      st,
   input  logic            tdi,
   output logic            ir_lsb,
   output logic [IR_W-1:0] ir_act,
   output insn_t           insn
);

   localparam int              PL_W    = IR_W - 1;
   localparam logic [IR_W-1:0] RST_PAT = '1;
   localparam logic [PL_W-1:0] OP_EXT  = PL_W'(0);
   localparam logic [PL_W-1:0] OP_SMP  = PL_W'(2);
   localparam logic [PL_W-1:0] OP_CTL  = PL_W'(3);

   logic [IR_W-1:0] sr;
   logic            par_ok;

   // capture / shift stage, rising edge
   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)                sr <= CAP_PAT;
      else if (st == ST_IR_CAP)  sr <= CAP_PAT;
      else if (st == ST_IR_SHF)  sr <= {tdi, sr[IR_W-1:1]};
   end

   // shadow stage, falling edge
   always_ff @(negedge tck or negedge por_n) begin
      if (!por_n)                ir_act <= RST_PAT;
      else if (st == ST_RESET)   ir_act <= RST_PAT;
      else if (st == ST_IR_UPD)  ir_act <= sr;
   end

   assign ir_lsb = sr[0];

   generate
      if (PARITY_CHECK) begin : g_par
         assign par_ok = ~(^ir_act);
      end else begin : g_nopar
         assign par_ok = 1'b1;
      end
   endgenerate

   always_comb begin
      insn.test = 1'b0;
      insn.path = PATH_BYPASS;
      if (par_ok) begin
         case (ir_act[PL_W-1:0])
            OP_EXT: begin insn.test = 1'b1; insn.path = PATH_BOUNDARY; end
            OP_SMP: begin insn.test = 1'b0; insn.path = PATH_BOUNDARY; end
            OP_CTL: begin insn.test = 1'b1; insn.path = PATH_CONTROL;  end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/scan_tap_out.sv
module scan_tap_out
   import scan_tap_pkg::*;
(
   input  logic       tck,
   input  logic       por_n,
   input  tap_state_e st,
   input  logic       tdi,
   input  logic       ir_lsb,
   input  logic       dr_tdo,
   input  logic       byp_sel,
   output logic       tdo,
   output logic       tdo_en,
   output logic       dr_update
);

   logic byp;
   logic nxt_bit;

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)                byp <= 1'b0;
      else if (st == ST_DR_CAP)  byp <= 1'b0;
      else if (st == ST_DR_SHF)  byp <= tdi;
   end

   always_comb begin
      if (st == ST_IR_SHF) nxt_bit = ir_lsb;
      else if (byp_sel)    nxt_bit = byp;
      else                 nxt_bit = dr_tdo;
   end

   always_ff @(negedge tck or negedge por_n) begin
      if (!por_n) begin
         tdo       <= 1'b0;
         tdo_en    <= 1'b0;
         dr_update <= 1'b0;
      end else begin
         tdo       <= nxt_bit;
         tdo_en    <= (st == ST_DR_SHF) || (st == ST_IR_SHF);
         dr_update <= (st == ST_DR_UPD) && !byp_sel;
      end
   end

endmodule

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
   import scan_tap_pkg::*;
#(
   parameter int               IR_W         = 8,
   parameter logic [IR_W-1:0]  CAP_PAT      = {1'b1, {(IR_W-2){1'b0}}, 1'b1},
   parameter bit               PARITY_CHECK = 1'b1
) (
   input  logic              tck,
   input  logic              por_n,
   input  logic              tms,
   input  logic              tdi,
   input  logic              dr_tdo,
   output logic              tdo,
   output logic              tdo_en,
   output logic              logic_reset,
   output logic              dr_capture,
   output logic              dr_shift,
   output logic              dr_update,
   output logic [PATH_W-1:0] dr_sel,
   output logic              test_mode
);

   generate
      if (IR_W < 4) begin : g_bad_width
         $error("scan_tap_ctrl: IR_W must be at least 4");
      end
   endgenerate

   tap_state_e      st;
   logic            ir_lsb;
   logic [IR_W-1:0] ir_act;
   insn_t           insn;
   logic            byp_sel;

   scan_tap_fsm u_fsm (
      .tck   (tck),
      .por_n (por_n),
      .tms   (tms),
      .st    (st)
   );

   scan_tap_ir #(
      .IR_W         (IR_W),
      .CAP_PAT      (CAP_PAT),
      .PARITY_CHECK (PARITY_CHECK)
   ) u_ir (
      .tck    (tck),
      .por_n  (por_n),
      .st     (st),
      .tdi    (tdi),
      .ir_lsb (ir_lsb),
      .ir_act (ir_act),
      .insn   (insn)
   );

   assign byp_sel = (insn.path == PATH_BYPASS);

   scan_tap_out u_out (
      .tck       (tck),
      .por_n     (por_n),
      .st        (st),
      .tdi       (tdi),
      .ir_lsb    (ir_lsb),
      .dr_tdo    (dr_tdo),
      .byp_sel   (byp_sel),
      .tdo       (tdo),
      .tdo_en    (tdo_en),
      .dr_update (dr_update)
   );

   assign logic_reset = (st == ST_RESET);
   assign dr_capture  = (st == ST_DR_CAP) && !byp_sel;
   assign dr_shift    = (st == ST_DR_SHF) && !byp_sel;
   assign dr_sel      = insn.path;
   assign test_mode   = insn.test;

endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
   import scan_tap_pkg::*;
#(
   parameter int IR_W         = 8,
   parameter bit PARITY_CHECK = 1'b1
) (
   input logic            tck,
   input logic            por_n,
   input logic            tms,
   input tap_state_e      st,
   input logic [IR_W-1:0] ir_act,
   input logic            tdo_en,
   input logic            logic_reset,
   input logic            test_mode,
   input logic            dr_capture,
   input logic            dr_shift,
   input logic            dr_update
);

   logic [2:0] ones;

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)          ones <= 3'd0;
      else if (!tms)       ones <= 3'd0;
      else if (ones != 3'd7) ones <= ones + 3'd1;
   end

   // R3: five high samples of tms always end in Test-Logic-Reset
   a_r3_five_ones: assert property (@(posedge tck) disable iff (!por_n)
      (ones >= 3'd5) |-> logic_reset);

   // R2: Test-Logic-Reset is held while tms stays high
   a_r2_reset_holds: assert property (@(posedge tck) disable iff (!por_n)
      (logic_reset && tms) |=> logic_reset);

   // R5: output enable matches the shift states seen at the rising edge
   a_r5_oe_in_shift: assert property (@(posedge tck) disable iff (!por_n)
      tdo_en == ((st == ST_DR_SHF) || (st == ST_IR_SHF)));

   // R10: at most one data-register strobe at a time
   a_r10_one_strobe: assert property (@(posedge tck) disable iff (!por_n)
      $onehot0({dr_capture, dr_shift, dr_update}));

   // R1: test-logic reset never coexists with test mode
   a_r1_reset_normal: assert property (@(posedge tck) disable iff (!por_n)
      logic_reset |=> !test_mode || !logic_reset);

   generate
      if (PARITY_CHECK) begin : g_par
         // R7: test mode only comes from an even-parity opcode
         a_r7_parity_of_test: assert property (@(posedge tck) disable iff (!por_n)
            test_mode |-> (^ir_act) == 1'b0);
      end
   endgenerate

endmodule

bind scan_tap_ctrl scan_tap_chk #(
   .IR_W         (IR_W),
   .PARITY_CHECK (PARITY_CHECK)
) u_chk (
   .tck         (tck),
   .por_n       (por_n),
   .tms         (tms),
   .st          (st),
   .ir_act      (ir_act),
   .tdo_en      (tdo_en),
   .logic_reset (logic_reset),
   .test_mode   (test_mode),
   .dr_capture  (dr_capture),
   .dr_shift    (dr_shift),
   .dr_update   (dr_update)
);

// File: tb/sim_scan_tap_ctrl.sv
`timescale 1ns/1ps
module sim_scan_tap_ctrl;

   logic       tck = 1'b0;
   logic       por_n = 1'b0;
   logic       tms = 1'b1;
   logic       tdi = 1'b0;
   logic       dr_tdo = 1'b0;
   logic       tdo, tdo_en, logic_reset, dr_capture, dr_shift, dr_update, test_mode;
   logic [1:0] dr_sel;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 tck = ~tck;

   scan_tap_ctrl u0 (
      .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .dr_tdo(dr_tdo),
      .tdo(tdo), .tdo_en(tdo_en), .logic_reset(logic_reset),
      .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
      .dr_sel(dr_sel), .test_mode(test_mode)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // one full cycle: drive after a falling edge, sample after the next one
   task automatic step(input logic m, input logic d);
      tms = m;
      tdi = d;
      @(posedge tck);
      @(negedge tck);
      #1;
   endtask

   // reference state graph, codes: 0 reset 1 idle 2..8 DR path 9..15 IR path
   function automatic int mnext(input int s, input logic m);
      case (s)
         0: return m ? 0 : 1;    1: return m ? 2 : 1;
         2: return m ? 9 : 3;    3: return m ? 5 : 4;
         4: return m ? 5 : 4;    5: return m ? 8 : 6;
         6: return m ? 7 : 6;    7: return m ? 8 : 4;
         8: return m ? 2 : 1;    9: return m ? 0 : 10;
         10: return m ? 12 : 11; 11: return m ? 12 : 11;
         12: return m ? 15 : 13; 13: return m ? 14 : 13;
         14: return m ? 15 : 11; 15: return m ? 2 : 1;
         default: return 0;
      endcase
   endfunction

   // {test_mode, dr_sel}
   function automatic logic [2:0] exp_insn(input logic [7:0] op);
      if (^op) return 3'b000;
      case (op[6:0])
         7'd0: return 3'b101;
         7'd2: return 3'b001;
         7'd3: return 3'b110;
         default: return 3'b000;
      endcase
   endfunction

   task automatic goto_idle();
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
      step(1'b0, 1'b0);
   endtask

   logic [2:0] cur_insn = 3'b000;

   // from Run-Test/Idle, load an opcode, return to Run-Test/Idle
   task automatic scan_ir(input logic [7:0] op);
      logic [7:0] got;
      step(1'b1, 1'b0);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      chk("R5 oe in shift-ir", tdo_en, 1);
      for (int i = 0; i < 8; i++) begin
         got[i] = tdo;
         step(i == 7, op[i]);
      end
      chk("R4 capture pattern", got, 8'h81);
      chk("R5 oe off in exit1-ir", tdo_en, 0);
      chk("R6 no change before update", {test_mode, dr_sel}, cur_insn);
      step(1'b1, 1'b0);
      cur_insn = exp_insn(op);
      chk((^op) ? "R7 parity fallback" : "R8 decode", {test_mode, dr_sel}, cur_insn);
      step(1'b0, 1'b0);
   endtask

   string paths [16] = '{"", "0", "01", "010", "0100", "0101", "01010", "010101",
                         "01011", "011", "0110", "01100", "01101", "011010",
                         "0110101", "011011"};

   initial begin
      logic [15:0] lf;
      int          m;
      logic [4:0]  pat;
      repeat (3) @(negedge tck);
      #1;
      chk("R1 reset state", {logic_reset, test_mode, dr_sel, tdo_en}, 5'b10000);
      por_n = 1'b1;
      step(1'b1, 1'b0);
      chk("R1 reset held", {logic_reset, test_mode, dr_sel}, 4'b1000);

      // R3: reach every state, then five ones
      for (int s = 0; s < 16; s++) begin
         goto_idle();
         for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
         for (int k = 0; k < paths[s].len(); k++) step(paths[s][k] == "1", 1'b0);
         chk("R2 reset flag per state", logic_reset, (s == 0));
         for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
         chk("R3 five ones to reset", logic_reset, 1);
      end

      // R2/R5: pseudo-random walk against the reference graph
      goto_idle();
      m  = 1;
      lf = 16'hACE1;
      for (int i = 0; i < 3000; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         step(lf[0] & lf[3], lf[5]);
         m = mnext(m, lf[0] & lf[3]);
         chk("R2 walk reset flag", logic_reset, (m == 0));
         chk("R5 walk output enable", tdo_en, (m == 4 || m == 11));
         if (m == 0) cur_insn = 3'b000;
      end

      // R4/R6/R7/R8: all opcodes
      goto_idle();
      cur_insn = 3'b000;
      for (int op = 0; op < 256; op++) scan_ir(8'(op));

      // R1: reset restores bypass after a test-mode opcode
      scan_ir(8'h00);
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
      chk("R1 reset restores bypass", {logic_reset, test_mode, dr_sel}, 4'b1000);
      step(1'b0, 1'b0);
      cur_insn = 3'b000;

      // R9: bypass path, all 5-bit patterns
      scan_ir(8'hFF);
      for (int p = 0; p < 32; p++) begin
         pat = 5'(p);
         step(1'b1, 1'b0);
         step(1'b0, 1'b0);
         chk("R9 no capture strobe", dr_capture, 0);
         step(1'b0, 1'b0);
         chk("R9 no shift strobe", dr_shift, 0);
         for (int i = 0; i < 5; i++) begin
            chk("R9 bypass delay", tdo, (i == 0) ? 0 : pat[i-1]);
            step(i == 4, pat[i]);
         end
         step(1'b1, 1'b0);
         chk("R9 no update strobe", dr_update, 0);
         step(1'b0, 1'b0);
      end

      // R10: boundary path strobes and serial return
      scan_ir(8'h82);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      chk("R10 capture strobe", {dr_capture, dr_sel}, 3'b101);
      step(1'b0, 1'b0);
      chk("R10 shift strobe", {dr_shift, tdo_en}, 2'b11);
      for (int i = 0; i < 4; i++) begin
         dr_tdo = i[0] ^ i[1];
         step(1'b0, 1'b0);
         chk("R10 tdo follows dr_tdo", tdo, i[0] ^ i[1]);
      end
      step(1'b1, 1'b0);
      chk("R10 shift strobe off in exit1", dr_shift, 0);
      step(1'b1, 1'b0);
      chk("R10 update strobe", dr_update, 1);
      step(1'b0, 1'b0);
      chk("R10 update strobe ends", dr_update, 0);

      // R8: control path in test mode
      scan_ir(8'h03);
      chk("R8 control path", {test_mode, dr_sel}, 3'b110);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule